// File: doc/BRIEF.md
# Weighted round-robin flow scheduler

This block chooses, once per cell time, which of N flows is sent next. Each flow has a priority register that holds its next time-to-service, and a service period that is the integer inverse of its weight. When a cell time begins (`cell_tick` high), the block looks at every flow whose queue is non-empty and whose flow-control enable is set. It picks the one whose time-to-service comes first, and on the next cycle it reports that flow's index together with a valid strobe. In the same cycle it pushes the chosen flow's time-to-service forward by that flow's service period. A flow with a short period therefore comes back sooner and gets a larger share of cell times.

Eligibility is recomputed from the two input masks on every cell time, with no stored history. Any number of flows may gain or lose eligibility at once, for example when a backpressure vector stops a whole group of flows. Selection is a full find-minimum over all eligible priorities, so bulk changes cost nothing extra.

Priorities are unsigned and wrap. The block keeps a virtual time equal to the priority the last served flow had at the moment it was chosen. Flows are ordered by their distance ahead of that virtual time, computed modulo 2^PRIO_W. This ordering is correct as long as all pending priorities lie within half the number range of the virtual time. Service periods and priorities are set through a small write port.

Top module: `wrr_sched`

## Requirements
- R1: After reset `grant_valid` is low, every priority is 0, every service period is 1 and the virtual time is 0. With all flows eligible, successive cell times therefore grant flows 0, 1, 2, ... in index order.
- R2: Flow i is eligible exactly when `queue_nonempty[i]` and `flow_enable[i]` are both 1. A flow that is not eligible is never granted.
- R3: `grant_valid` is high in the cycle after a cycle in which `cell_tick` was high and at least one flow was eligible. In every other cycle it is low.
- R4: The granted flow has the smallest key (priority minus virtual time, modulo 2^PRIO_W) among the eligible flows. When several flows share that smallest key, the lowest index wins.
- R5: When a flow is granted, its priority becomes old priority plus its service period (modulo 2^PRIO_W), and the virtual time becomes the old priority of that flow.
- R6: A cell time with no eligible flow, or a cycle without `cell_tick`, changes no priority and leaves the virtual time unchanged.
- R7: A write with `wr_field` = 0 sets the service period of flow `wr_flow` to `wr_data[PERIOD_W-1:0]`. A write with `wr_field` = 1 sets its priority to `wr_data`. Both take effect from the next cycle. A priority write to the flow being served in the same cycle overrides the service update.
- R8: Eligibility changes for any number of flows take effect in the same cycle as they appear on the inputs, with no settling delay.
- R9: Priorities that have wrapped past zero are still ordered after those just below the wrap point, as long as all pending priorities lie within half the range of the virtual time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_tick | input | 1 | Start of a cell time; requests one selection |
| queue_nonempty | input | N_FLOWS | Per-flow queue non-empty flags |
| flow_enable | input | N_FLOWS | Per-flow flow-control enables (1 = may send) |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_flow | input | IDX_W | Flow index to write |
| wr_field | input | 1 | 0 = service period, 1 = priority |
| wr_data | input | PRIO_W | Write data |
| grant_valid | output | 1 | A flow was selected in the previous cycle |
| grant_flow | output | IDX_W | Index of the selected flow |

## Verification
The bound checker watches four rules on every cycle:
- the valid strobe appears exactly one cycle after a cell time that had eligible flows;
- the granted flow was eligible;
- the granted flow's priority advanced by its own period;
- the priority table stays frozen when nothing was served or written.

Other behaviours need the bench's reference model and chosen scenarios:
- that the winner is truly the minimum;
- tie-breaking by lowest index;
- the reset contents;
- the precedence of a priority write over service;
- correct ordering across the wrap point.

// File: rtl/wrr_pkg.sv
`timescale 1ns/1ps
package wrr_pkg;

    // Field selector for the configuration write port
    typedef enum logic {
        FIELD_PERIOD = 1'b0,
        FIELD_PRIO   = 1'b1
    } wr_field_e;

endpackage

// File: rtl/wrr_min_select.sv
`timescale 1ns/1ps
// Find-minimum over eligible flows, keyed by distance ahead of virtual time.
module wrr_min_select #(
    parameter int N_FLOWS = 16,
    parameter int PRIO_W  = 16,
    parameter int IDX_W   = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1
) (
    input  logic [N_FLOWS-1:0][PRIO_W-1:0] prio_i,
    input  logic [N_FLOWS-1:0]             elig_i,
    input  logic [PRIO_W-1:0]              vtime_i,
    output logic                           found_o,
    output logic [IDX_W-1:0]               idx_o
);

    logic [N_FLOWS-1:0][PRIO_W-1:0] key;

    // Wrap-aware key: unsigned distance from the virtual time
    for (genvar g = 0; g < N_FLOWS; g++) begin : g_key
        assign key[g] = prio_i[g] - vtime_i;
    end

    logic [PRIO_W-1:0] best;

    // Linear scan; strict less-than keeps the lowest index on ties
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < N_FLOWS; i++) begin
            if (elig_i[i] && (!found_o || (key[i] < best))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                best    = key[i];
            end
        end
    end

endmodule

// File: rtl/wrr_flow_table.sv
`timescale 1ns/1ps
// Per-flow priority and service-period registers.
module wrr_flow_table
    import wrr_pkg::*;
#(
    parameter int N_FLOWS  = 16,
    parameter int PRIO_W   = 16,
    parameter int PERIOD_W = 8,
    parameter int IDX_W    = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             serve_en,
    input  logic [IDX_W-1:0]                 serve_idx,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  wr_field_e                        wr_field,
    input  logic [PRIO_W-1:0]                wr_data,
    output logic [N_FLOWS-1:0][PRIO_W-1:0]   prio_o,
    output logic [N_FLOWS-1:0][PERIOD_W-1:0] period_o
);

    typedef struct packed {
        logic [N_FLOWS-1:0][PRIO_W-1:0]   prio;
        logic [N_FLOWS-1:0][PERIOD_W-1:0] period;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        // Service update first
        if (serve_en) begin
            tbl_d.prio[serve_idx] = tbl_q.prio[serve_idx]
                                  + PRIO_W'(tbl_q.period[serve_idx]);
        end
        // A configuration write takes precedence
        if (wr_en) begin
            if (wr_field == FIELD_PRIO) begin
                tbl_d.prio[wr_idx] = wr_data;
            end else begin
                tbl_d.period[wr_idx] = wr_data[PERIOD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q.prio <= '0;
            for (int i = 0; i < N_FLOWS; i++) begin
                tbl_q.period[i] <= PERIOD_W'(1);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign prio_o   = tbl_q.prio;
    assign period_o = tbl_q.period;

endmodule

// File: rtl/wrr_sched.sv
`timescale 1ns/1ps
// Cell-time scheduler: serves the eligible flow whose time-to-service is nearest.
module wrr_sched
    import wrr_pkg::*;
#(
    parameter int N_FLOWS  = 16,
    parameter int PRIO_W   = 16,
    parameter int PERIOD_W = 8,
    localparam int IDX_W   = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cell_tick,
    input  logic [N_FLOWS-1:0] queue_nonempty,
    input  logic [N_FLOWS-1:0] flow_enable,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_flow,
    input  logic               wr_field,
    input  logic [PRIO_W-1:0]  wr_data,
    output logic               grant_valid,
    output logic [IDX_W-1:0]   grant_flow
);

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] vtime;
    } sched_t;

    sched_t st_d, st_q;

    logic [N_FLOWS-1:0][PRIO_W-1:0]   prio_tbl;
    logic [N_FLOWS-1:0][PERIOD_W-1:0] period_tbl;
    logic [N_FLOWS-1:0]               elig;
    logic                             found;
    logic [IDX_W-1:0]                 sel_idx;
    logic                             serve;

    assign elig  = queue_nonempty & flow_enable;
    assign serve = cell_tick & found;

    wrr_min_select #(
        .N_FLOWS (N_FLOWS),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) min_i (
        .prio_i  (prio_tbl),
        .elig_i  (elig),
        .vtime_i (st_q.vtime),
        .found_o (found),
        .idx_o   (sel_idx)
    );

    wrr_flow_table #(
        .N_FLOWS  (N_FLOWS),
        .PRIO_W   (PRIO_W),
        .PERIOD_W (PERIOD_W),
        .IDX_W    (IDX_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .serve_en  (serve),
        .serve_idx (sel_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_flow),
        .wr_field  (wr_field_e'(wr_field)),
        .wr_data   (wr_data),
        .prio_o    (prio_tbl),
        .period_o  (period_tbl)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = serve;
        if (serve) begin
            st_d.idx   = sel_idx;
            st_d.vtime = prio_tbl[sel_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.valid;
    assign grant_flow  = st_q.idx;

endmodule

// File: rtl/wrr_sched_chk.sv
`timescale 1ns/1ps
module wrr_sched_chk #(
    parameter int N_FLOWS  = 16,
    parameter int PRIO_W   = 16,
    parameter int PERIOD_W = 8,
    parameter int IDX_W    = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             cell_tick,
    input logic [N_FLOWS-1:0]               queue_nonempty,
    input logic [N_FLOWS-1:0]               flow_enable,
    input logic                             wr_en,
    input logic [IDX_W-1:0]                 wr_flow,
    input logic                             wr_field,
    input logic                             grant_valid,
    input logic [IDX_W-1:0]                 grant_flow,
    input logic [N_FLOWS-1:0][PRIO_W-1:0]   prio_tbl,
    input logic [N_FLOWS-1:0][PERIOD_W-1:0] period_tbl
);

    logic [N_FLOWS-1:0]               elig_prev;
    logic [N_FLOWS-1:0][PRIO_W-1:0]   prio_prev;
    logic [N_FLOWS-1:0][PERIOD_W-1:0] period_prev;
    logic                             wr_prev;
    logic                             wr_field_prev;
    logic [IDX_W-1:0]                 wr_flow_prev;
    logic                             hit_prio_wr;

    always_ff @(posedge clk) begin
        elig_prev     <= queue_nonempty & flow_enable;
        prio_prev     <= prio_tbl;
        period_prev   <= period_tbl;
        wr_prev       <= wr_en;
        wr_field_prev <= wr_field;
        wr_flow_prev  <= wr_flow;
    end

    assign hit_prio_wr = wr_prev && wr_field_prev && (wr_flow_prev == grant_flow);

    a_r3_valid_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (grant_valid == $past(cell_tick && (|(queue_nonempty & flow_enable)))));

    a_r2_granted_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && grant_valid) |-> elig_prev[grant_flow]);

    a_r5_prio_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && grant_valid && !hit_prio_wr) |->
        (prio_tbl[grant_flow] == prio_prev[grant_flow] + PRIO_W'(period_prev[grant_flow])));

    a_r6_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !wr_prev && !grant_valid) |-> $stable(prio_tbl));

endmodule

bind wrr_sched wrr_sched_chk #(
    .N_FLOWS  (N_FLOWS),
    .PRIO_W   (PRIO_W),
    .PERIOD_W (PERIOD_W),
    .IDX_W    (IDX_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cell_tick      (cell_tick),
    .queue_nonempty (queue_nonempty),
    .flow_enable    (flow_enable),
    .wr_en          (wr_en),
    .wr_flow        (wr_flow),
    .wr_field       (wr_field),
    .grant_valid    (grant_valid),
    .grant_flow     (grant_flow),
    .prio_tbl       (prio_tbl),
    .period_tbl     (period_tbl)
);

// File: tb/wrr_sched_tb.sv
`timescale 1ns/1ps
module wrr_sched_tb_top;

    localparam int N  = 16;
    localparam int PW = 16;
    localparam int DW = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cell_tick;
    logic [N-1:0]  queue_nonempty;
    logic [N-1:0]  flow_enable;
    logic          wr_en;
    logic [IW-1:0] wr_flow;
    logic          wr_field;
    logic [PW-1:0] wr_data;
    logic          grant_valid;
    logic [IW-1:0] grant_flow;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    // Reference model state
    logic [PW-1:0] prio_m [N];
    logic [DW-1:0] per_m  [N];
    logic [PW-1:0] vt_m;

    always #4 clk = ~clk; // 125 MHz

    wrr_sched #(.N_FLOWS(N), .PRIO_W(PW), .PERIOD_W(DW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cell_tick      (cell_tick),
        .queue_nonempty (queue_nonempty),
        .flow_enable    (flow_enable),
        .wr_en          (wr_en),
        .wr_flow        (wr_flow),
        .wr_field       (wr_field),
        .wr_data        (wr_data),
        .grant_valid    (grant_valid),
        .grant_flow     (grant_flow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected winner: smallest wrap-aware key, lowest index on ties
    function automatic void pick(input logic [N-1:0] el, output logic fnd, output logic [IW-1:0] idx);
        logic [PW-1:0] best = '0;
        fnd = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            logic [PW-1:0] k;
            k = prio_m[i] - vt_m;
            if (el[i] && (!fnd || k < best)) begin
                fnd  = 1'b1;
                idx  = IW'(i);
                best = k;
            end
        end
    endfunction

    task automatic cycle(input logic tick, input logic [N-1:0] q, input logic [N-1:0] f,
                         input logic we, input logic [IW-1:0] wi, input logic wf,
                         input logic [PW-1:0] wd, input string tag);
        logic          ev;
        logic [IW-1:0] ei;
        cell_tick      = tick;
        queue_nonempty = q;
        flow_enable    = f;
        wr_en          = we;
        wr_flow        = wi;
        wr_field       = wf;
        wr_data        = wd;
        pick(q & f, ev, ei);
        ev = ev & tick;
        if (ev) begin
            vt_m       = prio_m[ei];
            prio_m[ei] = prio_m[ei] + PW'(per_m[ei]);
        end
        if (we) begin
            if (wf) prio_m[wi] = wd;
            else    per_m[wi]  = wd[DW-1:0];
        end
        @(posedge clk);
        @(negedge clk);
        chk(grant_valid === ev, {tag, " valid"}, int'(grant_valid), int'(ev));
        if (ev) chk(grant_flow === ei, {tag, " flow"}, int'(grant_flow), int'(ei));
    endtask

    task automatic tick_only(input logic [N-1:0] q, input logic [N-1:0] f, input string tag);
        cycle(1'b1, q, f, 1'b0, '0, 1'b0, '0, tag);
    endtask

    task automatic wr(input logic [IW-1:0] wi, input logic wf, input logic [PW-1:0] wd, input string tag);
        cycle(1'b0, '0, '0, 1'b1, wi, wf, wd, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            prio_m[i] = '0;
            per_m[i]  = DW'(1);
        end
        vt_m           = '0;
        rst_n          = 1'b0;
        cell_tick      = 1'b0;
        queue_nonempty = '0;
        flow_enable    = '0;
        wr_en          = 1'b0;
        wr_flow        = '0;
        wr_field       = 1'b0;
        wr_data        = '0;
        repeat (3) @(negedge clk);
        chk(grant_valid === 1'b0, "R1 reset valid", int'(grant_valid), 0);
        rst_n = 1'b1;

        // R1/R4: reset contents give plain index order under ties
        for (int k = 0; k < 20; k++) tick_only('1, '1, "R1 R4 reset order");

        // R3: no tick, and tick with no eligible flow
        cycle(1'b0, '1, '1, 1'b0, '0, 1'b0, '0, "R3 no tick");
        tick_only('0, '1, "R3 R6 empty queues");
        tick_only('1, '0, "R3 R6 all stopped");

        // R2: only flows with both bits set
        for (int k = 0; k < 8; k++) tick_only(16'hF0F0, 16'h3C3C, "R2 masked");

        // R8: whole groups flip every cycle
        for (int k = 0; k < 8; k++)
            tick_only(16'hFFFF, (k % 2 == 0) ? 16'h00FF : 16'hFF00, "R8 group flip");

        // R7/R5: weights 1 and 3 between flows 0 and 1
        wr(4'd0, 1'b0, 16'd1, "R7 write period");
        wr(4'd1, 1'b0, 16'd3, "R7 write period");
        wr(4'd0, 1'b1, 16'd500, "R7 write prio");
        wr(4'd1, 1'b1, 16'd500, "R7 write prio");
        for (int k = 0; k < 12; k++) tick_only(16'h0003, 16'hFFFF, "R5 R7 weighted");

        // R7: priority write collides with service of the same flow
        cycle(1'b1, 16'h0020, 16'hFFFF, 1'b1, 4'd5, 1'b1, 16'd900, "R7 write wins");
        tick_only(16'h0021, 16'hFFFF, "R7 after collision");

        // R9: wrap past zero
        wr(4'd2, 1'b0, 16'd4, "R9 setup");
        wr(4'd3, 1'b0, 16'd4, "R9 setup");
        wr(4'd2, 1'b1, 16'hFFFE, "R9 setup");
        wr(4'd3, 1'b1, 16'h0003, "R9 setup");
        wr(4'd4, 1'b1, 16'hFFF0, "R9 setup");
        tick_only(16'h0010, 16'hFFFF, "R9 anchor");
        for (int k = 0; k < 8; k++) tick_only(16'h000C, 16'hFFFF, "R9 wrap order");

        // R8: random mixed stimulus
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0]  q, f;
            logic          we, wf;
            logic [IW-1:0] wi;
            logic [PW-1:0] wd;
            q  = N'($urandom());
            case ($urandom_range(0, 3))
                0:       f = '0;
                1:       f = '1;
                default: f = N'($urandom());
            endcase
            we = ($urandom_range(0, 9) == 0);
            wi = IW'($urandom());
            wf = 1'($urandom());
            wd = wf ? (vt_m + PW'($urandom_range(0, 300))) : PW'($urandom_range(1, 20));
            cycle(($urandom_range(0, 3) != 0), q, f, we, wi, wf, wd, "R8 R4 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule